// File: doc/BRIEF.md
# Memory Range Zero-Fill Engine

This block clears a contiguous span of memory on command. Software programs the lowest and the highest byte address of the span (both inclusive) through a small 32-bit register slave, then writes a command word. A command word of 0x11 starts a clear. The engine issues a sequence of zero-data write requests, each with a start address and a byte count, to a simple memory write port.

Each request is held on the port until the port accepts it. While the clear is in progress the engine reports busy. A one-cycle done pulse marks completion. A command the engine does not recognise, or a span whose end lies below its start, sets an error flag and produces no memory traffic.

Top module: `zfill_engine`

## Requirements
- R1: After reset, busy, done, err and mem_req are low, and the start-address and end-address registers read back as zero.
- R2: Register offsets: start address at 0x3030, end address at 0x3038, command at 0x3800. A read returns the stored value on bus_rdata in the cycle after bus_ren. A command read returns the last command accepted while idle. Any other offset reads as zero.
- R3: A write of 0x11 to the command offset while idle, with end >= start, sets busy and mem_req in the next cycle, with mem_addr equal to the start address.
- R4: Request n carries a byte count of min(remaining, 4096), where remaining starts at end - start + 1. Each request's address is the previous address plus the previous count. The counts sum to end - start + 1.
- R5: While mem_req is high and mem_ready is low, mem_req, mem_addr and mem_len hold their values.
- R6: In the cycle after the last request is accepted, done is high for exactly one cycle, and busy and mem_req are low.
- R7: A command word other than 0x11, written while idle, sets err and issues no requests.
- R8: A 0x11 command whose end address is below its start address sets err and issues no requests. busy and err are never high together.
- R9: A command write made while busy is ignored. It does not change err, the stored command or the request sequence.
- R10: A command write accepted while idle replaces err. A valid 0x11 start clears err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after bus_ren |
| mem_req | output | 1 | Zero-write request valid |
| mem_addr | output | 32 | First byte address of the request |
| mem_len | output | 13 | Byte count of the request, 1 to 4096 |
| mem_ready | input | 1 | Memory port accepts the current request |
| busy | output | 1 | Clear in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command rejected |

## Verification
The hardest case to reach from the ports is a command write that arrives while a clear is in flight. It has to land while a request is stalled on the port and must leave both the error flag and the chunk sequence untouched.

The stimulus holds mem_ready low on the first cycle of a clear and injects an unknown command in that same cycle. It then checks the error flag, the held request and every following chunk. Random spans with random ready stalls exercise the chunk split around the 4096-byte limit. Directed spans of 1, 4096 and 4097 bytes pin down its edges.

// File: rtl/zf_pkg.sv
package zf_pkg;
  localparam logic [15:0] OFS_FIRST = 16'h3030;
  localparam logic [15:0] OFS_LAST  = 16'h3038;
  localparam logic [15:0] OFS_CMD   = 16'h3800;
  localparam logic [31:0] CMD_ZERO  = 32'h0000_0011;

  typedef enum logic {ST_IDLE, ST_RUN} zf_state_e;
endpackage

// File: rtl/zf_regfile.sv
module zf_regfile
  import zf_pkg::*;
#(
  parameter int BUS_AW = 16,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wen,
  input  logic              ren,
  input  logic [BUS_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic              busy,
  output logic [DW-1:0]     first_o,
  output logic [DW-1:0]     last_o,
  output logic              start_o,
  output logic              err_o
);
  logic [DW-1:0] first_q, last_q, cmd_q;
  logic          err_q;
  logic          cmd_wr, cmd_take, cmd_good;

  assign cmd_wr   = wen && (addr == BUS_AW'(OFS_CMD));
  assign cmd_take = cmd_wr && !busy;
  assign cmd_good = (wdata == DW'(CMD_ZERO)) && (last_q >= first_q);
  assign start_o  = cmd_take && cmd_good;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      cmd_q   <= '0;
      err_q   <= 1'b0;
    end else if (wen) begin
      if (addr == BUS_AW'(OFS_FIRST)) first_q <= wdata;
      if (addr == BUS_AW'(OFS_LAST))  last_q  <= wdata;
      if (cmd_take) begin
        cmd_q <= wdata;
        err_q <= !cmd_good;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (ren) begin
      if (addr == BUS_AW'(OFS_FIRST))     rdata <= first_q;
      else if (addr == BUS_AW'(OFS_LAST)) rdata <= last_q;
      else if (addr == BUS_AW'(OFS_CMD))  rdata <= cmd_q;
      else                                rdata <= '0;
    end
  end

  assign first_o = first_q;
  assign last_o  = last_q;
  assign err_o   = err_q;

  assert_busy_cmd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> ($stable(err_q) && $stable(cmd_q)));
endmodule

// File: rtl/zf_chunker.sv
module zf_chunker
  import zf_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CHUNK_BYTES = 4096,
  parameter int LEN_W       = $clog2(CHUNK_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    first,
  input  logic [DW-1:0]    last,
  input  logic             mem_ready,
  output logic             mem_req,
  output logic [DW-1:0]    mem_addr,
  output logic [LEN_W-1:0] mem_len,
  output logic             done
);
  localparam int RW = DW + 1;
  localparam logic [RW-1:0] CHUNK_R = RW'(CHUNK_BYTES);

  zf_state_e         state_q;
  logic [DW-1:0]     addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [RW-1:0]     rem_q;
  logic              done_q;
  logic [RW-1:0]     span;
  logic [LEN_W-1:0]  take_first, take_next;

  function automatic logic [LEN_W-1:0] take(input logic [RW-1:0] r);
    return (r > CHUNK_R) ? LEN_W'(CHUNK_BYTES) : r[LEN_W-1:0];
  endfunction

  assign span       = {1'b0, last} - {1'b0, first} + RW'(1);
  assign take_first = take(span);
  assign take_next  = take(rem_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= '0;
      rem_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q  <= first;
            len_q   <= take_first;
            rem_q   <= span - RW'(take_first);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (mem_ready) begin
            if (rem_q == '0) begin
              state_q <= ST_IDLE;
              len_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              addr_q <= addr_q + DW'(len_q);
              len_q  <= take_next;
              rem_q  <= rem_q - RW'(take_next);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req  = (state_q == ST_RUN);
  assign mem_addr = addr_q;
  assign mem_len  = len_q;
  assign done     = done_q;

  assert_hold_while_stalled_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

  assert_len_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_len != '0 && mem_len <= LEN_W'(CHUNK_BYTES)));

  assert_contiguous_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready && rem_q != '0) |=>
      (mem_addr == $past(mem_addr) + DW'($past(mem_len))));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_req && $past(mem_req && mem_ready)));
endmodule

// File: rtl/zfill_engine.sv
module zfill_engine
  import zf_pkg::*;
#(
  parameter int BUS_AW      = 16,
  parameter int DW          = 32,
  parameter int CHUNK_BYTES = 4096,
  localparam int LEN_W      = $clog2(CHUNK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              mem_req,
  output logic [DW-1:0]     mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  input  logic              mem_ready,
  output logic              busy,
  output logic              done,
  output logic              err
);
  logic [DW-1:0] first_w, last_w;
  logic          start_w, req_w;

  zf_regfile #(.BUS_AW(BUS_AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wen     (bus_wen),
    .ren     (bus_ren),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .busy    (req_w),
    .first_o (first_w),
    .last_o  (last_w),
    .start_o (start_w),
    .err_o   (err)
  );

  zf_chunker #(.DW(DW), .CHUNK_BYTES(CHUNK_BYTES), .LEN_W(LEN_W)) u_chunk (
    .clk       (clk),
    .rst       (rst),
    .start     (start_w),
    .first     (first_w),
    .last      (last_w),
    .mem_ready (mem_ready),
    .mem_req   (req_w),
    .mem_addr  (mem_addr),
    .mem_len   (mem_len),
    .done      (done)
  );

  assign mem_req = req_w;
  assign busy    = req_w;

  assert_no_busy_with_err_R8: assert property (@(posedge clk) disable iff (rst)
    !(busy && err));

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (rst)
    start_w |=> (busy && mem_addr == $past(first_w)));
endmodule

// File: tb/sim_zfill_engine.sv
module sim_zfill_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mem_req, mem_ready = 1'b0, busy, done, err;
  logic [31:0] mem_addr;
  logic [12:0] mem_len;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  zfill_engine u0 (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_ready(mem_ready), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic longint piece(input longint r);
    return (r > 4096) ? 4096 : r;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic run_fill(input logic [31:0] f, input logic [31:0] l, input bit poke);
    longint rem;
    logic [31:0] ea, ha;
    logic [12:0] hl;
    bit first_it, rdy;
    wr(16'h3030, f);
    wr(16'h3038, l);
    wr(16'h3800, 32'h11);
    chk("R3 busy after start", busy, 1);
    chk("R3 first addr", mem_addr, f);
    chk("R10 err cleared by valid start", err, 0);
    rem = longint'(l) - longint'(f) + 1;
    ea = f;
    first_it = 1'b1;
    while (rem > 0) begin
      chk("R4 request present", mem_req, 1);
      rdy = ($urandom_range(0, 2) != 0) && !first_it;
      mem_ready = rdy;
      if (poke && first_it) begin
        bus_wen = 1'b1; bus_addr = 16'h3800; bus_wdata = 32'h5A;
      end
      if (rdy) begin
        chk("R4 chunk addr", mem_addr, ea);
        chk("R4 chunk len", mem_len, piece(rem));
      end
      ha = mem_addr; hl = mem_len;
      @(negedge clk);
      bus_wen = 1'b0; mem_ready = 1'b0;
      if (rdy) begin
        ea = ea + 32'(piece(rem));
        rem = rem - piece(rem);
      end else begin
        chk("R5 addr held", mem_addr, ha);
        chk("R5 len held", mem_len, hl);
      end
      if (poke && first_it) chk("R9 err unchanged by busy cmd", err, 0);
      first_it = 1'b0;
    end
    chk("R6 done pulse", done, 1);
    chk("R6 busy low at end", busy, 0);
    chk("R6 req low at end", mem_req, 0);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
  endtask

  task automatic run_bad(input logic [31:0] f, input logic [31:0] l, input logic [31:0] c,
                         input string tag);
    wr(16'h3030, f);
    wr(16'h3038, l);
    wr(16'h3800, c);
    chk({tag, " err set"}, err, 1);
    chk({tag, " not busy"}, busy, 0);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " no request"}, mem_req, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] f, l;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 req", mem_req, 0);
    rd(16'h3030, d); chk("R1 first reg", d, 0);
    rd(16'h3038, d); chk("R1 last reg", d, 0);

    wr(16'h3030, 32'hDEAD_0000);
    wr(16'h3038, 32'h0BAD_F00D);
    rd(16'h3030, d); chk("R2 first readback", d, 32'hDEAD_0000);
    rd(16'h3038, d); chk("R2 last readback", d, 32'h0BAD_F00D);
    rd(16'h3034, d); chk("R2 other offset", d, 0);

    run_fill(32'h0000_1000, 32'h0000_1000, 1'b0);
    rd(16'h3800, d); chk("R2 cmd readback", d, 32'h11);
    run_fill(32'h0000_2000, 32'h0000_2FFF, 1'b0);
    run_fill(32'h0000_5000, 32'h0000_6000, 1'b0);

    run_bad(32'h100, 32'h200, 32'h12, "R7 unknown cmd");
    rd(16'h3800, d); chk("R2 cmd holds rejected code", d, 32'h12);
    run_bad(32'h100, 32'h200, 32'h0, "R7 zero cmd");
    run_bad(32'h9000, 32'h8FFF, 32'h11, "R8 reversed range");

    run_fill(32'h0001_0000, 32'h0001_2345, 1'b1);
    rd(16'h3800, d); chk("R9 cmd reg unchanged", d, 32'h11);

    for (int k = 0; k < 20; k++) begin
      f = $urandom & 32'h0FFF_FFFF;
      l = f + 32'($urandom_range(1, 20000)) - 32'd1;
      run_fill(f, l, k[0]);
      if (k % 5 == 4) run_bad(f, l, $urandom | 32'h100, "R7 random unknown");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule